// File: doc/BRIEF.md
# Four-by-four tree multiplier

This block multiplies two 4-bit unsigned operands and returns the full 8-bit product in the same cycle. It has no clock and no internal state. Partial products come from an AND array. A two-stage reduction tree then brings every column down to at most two bits, using three full adders and three half adders in total. A ripple merge adder turns the two remaining rows into the product.

The netlist is fixed for the 4x4 case. Each compressor cell is placed by hand so that the count of adder cells stays at its minimum. The block suits a small arithmetic unit where a fast multiply is needed and a full array of adder cells would be too large.

Top module: `treeMul4x4`

## Requirements
- R1: For every pair of 4-bit unsigned operands, `product` equals opA multiplied by opB, as an 8-bit unsigned value.
- R2: When either operand is zero, `product` is zero.
- R3: Product bit 0 equals opA[0] AND opB[0].
- R4: With both operands at 15, `product` is 225 (8'hE1), the largest product the block can produce.
- R5: When one operand is 1, `product` equals the other operand, zero-extended to 8 bits.
- R6: When opB is 2^k (k from 0 to 3), `product` equals opA shifted left by k places.
- R7: Swapping the two operands leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | Multiplicand, unsigned |
| opB | input | 4 | Multiplier, unsigned |
| product | output | 8 | Unsigned product of opA and opB |

## Verification
The path is combinational, so a miswired compressor or a dropped carry shows at `product` as soon as the inputs settle. It does not wait for a later cycle. Each cell feeds a fixed column, so a fault gives a wrong value only for operand pairs that set the bits reaching that cell. That is why the bench walks all 256 operand pairs, in both orders, and checks every bit of each product. A lost carry in the upper columns appears only for large operands, such as 15 times 15.

// File: rtl/treeMulPkg.sv
package treeMulPkg;
  localparam int OpWidth   = 4;
  localparam int ProdWidth = 2 * OpWidth;
  localparam int NumCols   = ProdWidth;

  typedef logic [OpWidth-1:0]   operand_t;
  typedef logic [ProdWidth-1:0] product_t;
  // ppBits[i][j] = opA[i] & opB[j], weight 2^(i+j)
  typedef logic [OpWidth-1:0][OpWidth-1:0] ppMatrix_t;

  // Two rows left after reduction, fed to the merge adder
  typedef struct packed {
    product_t rowSum;
    product_t rowCarry;
  } twoRows_t;
endpackage

// File: rtl/mulHalfAdder.sv
module mulHalfAdder (
  input  logic inX,
  input  logic inY,
  output logic sumOut,
  output logic carryOut
);
  always_comb begin
    sumOut   = inX ^ inY;
    carryOut = inX & inY;
  end
endmodule

// File: rtl/mulFullAdder.sv
module mulFullAdder (
  input  logic inX,
  input  logic inY,
  input  logic inZ,
  output logic sumOut,
  output logic carryOut
);
  always_comb begin
    sumOut   = inX ^ inY ^ inZ;
    carryOut = (inX & inY) | (inX & inZ) | (inY & inZ);
  end
endmodule

// File: rtl/mulPartialGen.sv
module mulPartialGen
  import treeMulPkg::*;
(
  input  operand_t  opA,
  input  operand_t  opB,
  output ppMatrix_t ppBits
);
  for (genvar i = 0; i < OpWidth; i++) begin : gRow
    for (genvar j = 0; j < OpWidth; j++) begin : gCol
      assign ppBits[i][j] = opA[i] & opB[j];
    end
  end

  // The number of set partial bits is the product of the operands' popcounts
  always_comb begin
    if (!$isunknown({opA, opB})) begin
      AST_PP_POPCOUNT: assert ($countones(ppBits) == $countones(opA) * $countones(opB))
        else $error("partial product popcount mismatch"); // R1
    end
  end
endmodule

// File: rtl/mulTreeReduce.sv
module mulTreeReduce
  import treeMulPkg::*;
(
  input  ppMatrix_t ppBits,
  output twoRows_t  rows
);
  // Stage one: half adders in column 3 and column 4
  logic s3a, c4a, s4a, c5a;
  // Stage two: half adder in column 2, full adders in columns 3, 4 and 5
  logic s2b, c3b, s3b, c4b, s4b, c5b, s5b, c6b;

  mulHalfAdder uHaCol3 (.inX(ppBits[3][0]), .inY(ppBits[2][1]),
                        .sumOut(s3a), .carryOut(c4a));
  mulHalfAdder uHaCol4 (.inX(ppBits[3][1]), .inY(ppBits[2][2]),
                        .sumOut(s4a), .carryOut(c5a));

  mulHalfAdder uHaCol2 (.inX(ppBits[2][0]), .inY(ppBits[1][1]),
                        .sumOut(s2b), .carryOut(c3b));
  mulFullAdder uFaCol3 (.inX(ppBits[1][2]), .inY(ppBits[0][3]), .inZ(s3a),
                        .sumOut(s3b), .carryOut(c4b));
  mulFullAdder uFaCol4 (.inX(ppBits[1][3]), .inY(s4a), .inZ(c4a),
                        .sumOut(s4b), .carryOut(c5b));
  mulFullAdder uFaCol5 (.inX(ppBits[3][2]), .inY(ppBits[2][3]), .inZ(c5a),
                        .sumOut(s5b), .carryOut(c6b));

  always_comb begin
    rows.rowSum   = {1'b0, ppBits[3][3], s5b, s4b, s3b, s2b, ppBits[1][0], ppBits[0][0]};
    rows.rowCarry = {1'b0, c6b, c5b, c4b, c3b, ppBits[0][2], ppBits[0][1], 1'b0};
  end

  // The weighted sum of the two rows must equal the weighted sum of the partial bits
  logic [ProdWidth:0] ppWeighted;
  always_comb begin
    ppWeighted = '0;
    for (int i = 0; i < OpWidth; i++) begin
      for (int j = 0; j < OpWidth; j++) begin
        if (ppBits[i][j]) ppWeighted = ppWeighted + ((ProdWidth+1)'(1) << (i + j));
      end
    end
    if (!$isunknown(ppBits)) begin
      AST_REDUCE_PRESERVES_SUM: assert ({1'b0, rows.rowSum} + {1'b0, rows.rowCarry} == ppWeighted)
        else $error("reduction changed the column-weighted sum"); // R1
      AST_COL0_DIRECT: assert (rows.rowCarry[0] == 1'b0 && rows.rowSum[0] == ppBits[0][0])
        else $error("column 0 not passed straight through"); // R3
    end
  end
endmodule

// File: rtl/mulMergeAdder.sv
module mulMergeAdder
  import treeMulPkg::*;
#(
  parameter int Width = ProdWidth
) (
  input  logic [Width-1:0] addA,
  input  logic [Width-1:0] addB,
  output logic [Width-1:0] sumOut
);
  logic [Width-1:0] carryChain;
  assign carryChain[0] = 1'b0;

  for (genvar i = 0; i < Width; i++) begin : gBit
    assign sumOut[i] = addA[i] ^ addB[i] ^ carryChain[i];
    if (i < Width - 1) begin : gCarry
      assign carryChain[i+1] = (addA[i] & addB[i]) | (carryChain[i] & (addA[i] ^ addB[i]));
    end
  end
endmodule

// File: rtl/treeMul4x4.sv
module treeMul4x4
  import treeMulPkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  output logic [7:0] product
);
  ppMatrix_t ppBits;
  twoRows_t  rows;

  mulPartialGen uPartial (.opA(opA), .opB(opB), .ppBits(ppBits));
  mulTreeReduce uReduce  (.ppBits(ppBits), .rows(rows));
  mulMergeAdder #(.Width(ProdWidth)) uMerge (
    .addA(rows.rowSum), .addB(rows.rowCarry), .sumOut(product));

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      AST_PRODUCT_EXACT: assert (product == ProdWidth'(opA) * ProdWidth'(opB))
        else $error("product mismatch"); // R1
      AST_ZERO_OPERAND: assert (!((opA == '0) || (opB == '0)) || (product == '0))
        else $error("zero operand gave nonzero product"); // R2
    end
  end
endmodule

// File: tb/tb_treeMul4x4.sv
module tb_treeMul4x4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [3:0] opA, opB;
  logic [7:0] product;

  treeMul4x4 dut (.opA(opA), .opB(opB), .product(product));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // {a, b, expected product}
  localparam int NVec = 10;
  localparam logic [15:0] vecTable [NVec] = '{
    {4'd0,  4'd0,  8'd0},
    {4'd1,  4'd1,  8'd1},
    {4'd3,  4'd5,  8'd15},
    {4'd7,  4'd7,  8'd49},
    {4'd15, 4'd15, 8'd225},
    {4'd8,  4'd8,  8'd64},
    {4'd12, 4'd11, 8'd132},
    {4'd9,  4'd6,  8'd54},
    {4'd15, 4'd1,  8'd15},
    {4'd10, 4'd13, 8'd130}
  };

  task automatic apply(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    opA = a;
    opB = b;
    #5;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, opA, opB, got, exp);
    end
  endtask

  initial begin
    opA = '0;
    opB = '0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // Settled state with zero inputs
    apply(4'd0, 4'd0);
    check("R2", product, 8'd0);

    // Vector table walk
    for (int v = 0; v < NVec; v++) begin
      apply(vecTable[v][15:12], vecTable[v][11:8]);
      check("R1", product, vecTable[v][7:0]);
    end

    // Exhaustive sweep, each pair also checked in swapped order
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [7:0] fwd;
        apply(4'(a), 4'(b));
        fwd = product;
        check("R1", product, 8'(a * b));
        check("R3", {7'd0, product[0]}, {7'd0, 1'(a & b & 1)});
        if (a == 0 || b == 0) check("R2", product, 8'd0);
        if (b == 1) check("R5", product, 8'(a));
        if (a == 1) check("R5", product, 8'(b));
        if (b == 1 || b == 2 || b == 4 || b == 8) check("R6", product, 8'(a) << $clog2(b));
        apply(4'(b), 4'(a));
        check("R7", product, fwd);
      end
    end

    // Corner: largest product
    apply(4'd15, 4'd15);
    check("R4", product, 8'hE1);
    apply(4'd15, 4'd0);
    check("R2", product, 8'd0);
    apply(4'd0, 4'd15);
    check("R2", product, 8'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule